// File: doc/BRIEF.md
# Sixteen-Clock Serial Register Target

This block is the serial-side front end of a register file. An external controller opens a frame by pulling the active-low select line, then gives exactly sixteen serial clock pulses. The first bit of the frame chooses between reading and writing. The next seven bits name a register, most significant bit first. The last eight bits carry the register byte. For a write that byte comes from the controller. For a read the block fetches the byte from the register array and shifts it out.

The serial clock idles high. The controller changes its data after each falling clock edge, and the block samples on each rising edge. The block changes its read data after falling edges in the same way. All serial pins are sampled by the block's own system clock through a short synchronizer. A mode input, taken from a configuration bit, picks the pin that carries the read data. It is either the dedicated output pin or the shared input pin, which is then turned around for the data half of a read frame. Pad drivers sit outside the block, so each output pin is given as a value and an enable.

A write reaches the register array only once a complete frame has closed. A frame with too few or too many clocks changes nothing.

Top module: `spi_reg_target`

## Requirements
- R1: After reset, both output enables, `reg_wr_en` and `reg_rd_en` are low.
- R2: Serial input is sampled on rising `sclk` edges while `cs_n` is low. Frame bit 0 is the direction (1 = read, 0 = write). Bits 1 to 7 are the register index, most significant bit first. Bits 8 to 15 are the data byte, most significant bit first.
- R3: A write frame of exactly 16 rising edges produces, after `cs_n` rises, one single-cycle `reg_wr_en` pulse carrying the frame's index on `reg_addr` and its byte on `reg_wr_data`.
- R4: A write frame closed after fewer than 16 rising edges (for example 10 or 15), or after more than 16 (for example 17), produces no `reg_wr_en` pulse, and the addressed register keeps its old value.
- R5: In a read frame, one single-cycle `reg_rd_en` pulse with the frame's index on `reg_addr` follows the 8th rising edge. `reg_rd_data` is taken in that same cycle.
- R6: In a read frame, the byte is driven most significant bit first. The first bit appears within 3 system clocks after the 9th falling `sclk` edge, and each later falling edge moves to the next bit.
- R7: The output enables stay low through bits 0 to 7, through the whole of a write frame, and from at most 3 system clocks after `cs_n` rises.
- R8: When `mode_3wire` is 1 at the falling edge of `cs_n`, read data appears on `sdio_o`/`sdio_oe` and `sdo_oe` stays low. When it is 0, the data appears on `sdo_o`/`sdo_oe` and `sdio_oe` stays low. A change of `mode_3wire` during the frame has no effect until the next frame.
- R9: `sdo_oe` and `sdio_oe` are never high together, and `reg_wr_en` and `reg_rd_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdio_i | input | 1 | Serial data in; also the shared line in 3-wire mode |
| mode_3wire | input | 1 | 1 selects read data on the shared line |
| sdo_o | output | 1 | Dedicated read data output value |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| sdio_o | output | 1 | Read data value for the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| reg_addr | output | ADDR_W | Register index of the current access |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W | Byte to write |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | DATA_W | Byte returned by the register array in the read strobe cycle |

## Verification
The properties assume that `cs_n` and `sclk` hold each level for at least four system clocks. With that hold time, a write strobe is raised while raw `cs_n` is still high, a read strobe while it is still low, and the enables are already off after four quiet cycles of deselection. The stimulus holds every serial level for eight system clocks and keeps `cs_n` high for sixteen between frames. Master data changes only on its low clock phase, and the bench reads outputs just before each rising edge it makes.

// File: rtl/spi_reg_pkg.sv
// Shared types for the serial register target.
// Assumes the frame is direction bit, index field and data field in that order.
package spi_reg_pkg;
    // Which part of the frame the receiver is in.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_DATA,
        PH_OVER
    } frame_phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Synchronizes a group of asynchronous pins into the clk domain and flags
// their edges. Assumes each pin holds a level longer than STAGES+1 clocks.
module spi_pin_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the pin through the synchronizer and keep the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
                prev  <= RST_VAL[b];
            end else begin
                chain <= {chain[STAGES-2:0], pin_i[b]};
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl_o[b]  = chain[STAGES-1];
        assign rise_o[b] = chain[STAGES-1] & ~prev;
        assign fall_o[b] = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/spi_frame_rx.sv
// Counts rising serial clocks in a frame, shifts in the command and data,
// raises a read request once the index is known and a write request when a
// complete frame closes. Assumes events come from spi_pin_sync.
module spi_frame_rx
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,        // synchronized select, active high
    input  logic              sel_open,   // select just asserted
    input  logic              sel_close,  // select just released
    input  logic              sclk_rise,
    input  logic              sdi,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_req_o,
    output logic              wr_req_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_OVER      = CNT_W'(FRAME_LEN + 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shift;
    logic [DATA_W-1:0] shift_nx;
    logic              rw_q;
    frame_phase_e      phase;

    assign shift_nx = {shift[DATA_W-2:0], sdi};

    // Phase of the frame, derived from the rising edge count.
    always_comb begin
        if (!sel)                    phase = PH_IDLE;
        else if (cnt <= CNT_ADDR_LAST) phase = PH_CMD;
        else if (cnt <= CNT_FULL)    phase = PH_DATA;
        else                         phase = PH_OVER;
    end

    // Count rising edges, saturating one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_open) begin
            cnt <= '0;
        end else if (sel && sclk_rise && cnt != CNT_OVER) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Shift serial data in and capture the direction bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift <= '0;
            rw_q  <= 1'b0;
        end else if (sel && sclk_rise) begin
            shift <= shift_nx;
            if (cnt == '0) rw_q <= sdi;
        end
    end

    // Latch the index and raise the read request on the last index bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o   <= '0;
            rd_req_o <= 1'b0;
        end else begin
            rd_req_o <= 1'b0;
            if (sel && sclk_rise && phase == PH_CMD && cnt == CNT_ADDR_LAST) begin
                addr_o   <= shift_nx[ADDR_W-1:0];
                rd_req_o <= rw_q;
            end
        end
    end

    // Commit a write only when a frame of exactly FRAME_LEN bits closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req_o  <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_req_o <= 1'b0;
            if (sel_close && cnt == CNT_FULL && !rw_q) begin
                wr_req_o  <= 1'b1;
                wr_data_o <= shift;
            end
        end
    end
endmodule

// File: rtl/spi_read_tx.sv
// Holds the fetched read byte and shifts it out on falling serial clocks,
// steering it to the dedicated or the shared pin by the mode latched at
// frame start. Assumes load arrives before the first data-phase falling edge.
module spi_read_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sel_open,
    input  logic              sclk_fall,
    input  logic              mode_3w,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic              sdio_o,
    output logic              sdio_oe
);
    logic [DATA_W-1:0] tx_sh;
    logic              armed;
    logic              driving;
    logic              bit_q;
    logic              mode_q;

    // Latch the pin choice once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= 1'b0;
        else if (sel_open) mode_q <= mode_3w;
    end

    // Load the byte, then move one bit out on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel || sel_open) begin
            tx_sh   <= '0;
            armed   <= 1'b0;
            driving <= 1'b0;
            bit_q   <= 1'b0;
        end else if (load) begin
            tx_sh <= load_data;
            armed <= 1'b1;
        end else if (armed && sclk_fall) begin
            driving <= 1'b1;
            bit_q   <= tx_sh[DATA_W-1];
            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    assign sdo_oe  = driving & ~mode_q;
    assign sdio_oe = driving & mode_q;
    assign sdo_o   = sdo_oe & bit_q;
    assign sdio_o  = sdio_oe & bit_q;
endmodule

// File: rtl/spi_reg_target.sv
// Top of the serial register target: pin synchronizer, frame receiver and
// read transmitter. Assumes serial levels last at least four clk cycles.
module spi_reg_target #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdio_i,
    input  logic              mode_3wire,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rd_data
);
    localparam int PIN_W = 3;
    localparam int P_CS  = 2;
    localparam int P_CLK = 1;
    localparam int P_DAT = 0;

    logic [PIN_W-1:0] lvl;
    logic [PIN_W-1:0] rise;
    logic [PIN_W-1:0] fall;
    logic             sel;

    spi_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({cs_n, sclk, sdio_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign sel = ~lvl[P_CS];

    spi_frame_rx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sel_open  (fall[P_CS]),
        .sel_close (rise[P_CS]),
        .sclk_rise (rise[P_CLK]),
        .sdi       (lvl[P_DAT]),
        .addr_o    (reg_addr),
        .rd_req_o  (reg_rd_en),
        .wr_req_o  (reg_wr_en),
        .wr_data_o (reg_wr_data)
    );

    spi_read_tx #(
        .DATA_W (DATA_W)
    ) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sel_open  (fall[P_CS]),
        .sclk_fall (fall[P_CLK]),
        .mode_3w   (mode_3wire),
        .load      (reg_rd_en),
        .load_data (reg_rd_data),
        .sdo_o     (sdo_o),
        .sdo_oe    (sdo_oe),
        .sdio_o    (sdio_o),
        .sdio_oe   (sdio_oe)
    );
endmodule

// File: rtl/spi_reg_target_chk.sv
// Property checker for spi_reg_target, attached by bind.
// Assumes cs_n and sclk hold each level for at least four clk cycles.
module spi_reg_target_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdo_oe,
    input logic sdio_oe,
    input logic reg_wr_en,
    input logic reg_rd_en
);
    a_r9_pins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe && sdio_oe));

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    a_r3_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    a_r3_write_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> cs_n);

    a_r5_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    a_r5_read_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> !cs_n);

    a_r7_quiet_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
            |-> (!sdo_oe && !sdio_oe));
endmodule

bind spi_reg_target spi_reg_target_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo_oe    (sdo_oe),
    .sdio_oe   (sdio_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en)
);

// File: tb/test_spi_reg_target.sv
// Directed bench for spi_reg_target: acts as serial controller and register array.
module test_spi_reg_target;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic       sdio_i = 1'b0;
    logic       mode_3wire = 1'b0;
    logic       sdo_o, sdo_oe, sdio_o, sdio_oe;
    logic [6:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;

    logic [7:0] mem [128];
    int wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
    logic [6:0] wr_addr_seen, rd_addr_seen;
    logic [7:0] wr_data_seen;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    spi_reg_target i_spi_reg_target (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
        .sdio_i (sdio_i), .mode_3wire (mode_3wire),
        .sdo_o (sdo_o), .sdo_oe (sdo_oe), .sdio_o (sdio_o), .sdio_oe (sdio_oe),
        .reg_addr (reg_addr), .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data),
        .reg_rd_en (reg_rd_en), .reg_rd_data (reg_rd_data)
    );

    assign reg_rd_data = mem[reg_addr];

    // Register array model and strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en) begin
                wr_cnt++;
                wr_addr_seen = reg_addr;
                wr_data_seen = reg_wr_data;
                mem[reg_addr] = reg_wr_data;
            end
            if (reg_rd_en) begin
                rd_cnt++;
                rd_addr_seen = reg_addr;
            end
            if ((reg_wr_en && reg_rd_en) || (sdo_oe && sdio_oe)) both_cnt++;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame: word is {rw, index[6:0], data[7:0]}, nrise rising clocks.
    task automatic spi_xfer(input logic [15:0] word, input int nrise, input logic m3,
                            input logic flip, output logic [7:0] rx, output int oe_err);
        logic rd;
        rd = word[15];
        rx = '0;
        oe_err = 0;
        mode_3wire = m3;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < nrise; i++) begin
            sclk = 1'b0;
            sdio_i = (i < 16) ? word[15-i] : 1'b0;
            wait_clk(HP);
            if (rd && i >= 8 && i < 16) begin
                if (m3 ? (!sdio_oe || sdo_oe) : (!sdo_oe || sdio_oe)) oe_err++;
                rx = {rx[6:0], (m3 ? sdio_o : sdo_o)};
            end else if (sdo_oe || sdio_oe) begin
                oe_err++;
            end
            sclk = 1'b1;
            if (flip && i == 3) mode_3wire = ~mode_3wire;
            wait_clk(HP);
            if (i == 7 && (sdo_oe || sdio_oe)) oe_err++;
        end
        cs_n = 1'b1;
        wait_clk(HP);
        if (sdo_oe || sdio_oe) oe_err++;
        wait_clk(HP);
        mode_3wire = m3;
    endtask

    task automatic t_reset();
        chk(!sdo_oe && !sdio_oe, "R1 enables", {sdo_oe, sdio_oe}, 0);
        chk(!reg_wr_en && !reg_rd_en, "R1 strobes", {reg_wr_en, reg_rd_en}, 0);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] d, input logic m3);
        logic [7:0] rx; int oe_err; int w0;
        w0 = wr_cnt;
        spi_xfer({1'b0, a, d}, 16, m3, 1'b0, rx, oe_err);
        chk(wr_cnt == w0 + 1, "R3 write count", wr_cnt - w0, 1);
        chk(wr_addr_seen == a, "R2 write index", wr_addr_seen, a);
        chk(wr_data_seen == d, "R2 R3 write byte", wr_data_seen, d);
        chk(oe_err == 0, "R7 no drive in write", oe_err, 0);
    endtask

    task automatic t_read(input logic [6:0] a, input logic m3, input logic flip);
        logic [7:0] rx; int oe_err; int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        spi_xfer({1'b1, a, 8'h00}, 16, m3, flip, rx, oe_err);
        chk(rd_cnt == r0 + 1, "R5 read count", rd_cnt - r0, 1);
        chk(rd_addr_seen == a, "R5 read index", rd_addr_seen, a);
        chk(rx == mem[a], "R6 read byte", rx, mem[a]);
        chk(oe_err == 0, "R7 R8 enable window", oe_err, 0);
        chk(wr_cnt == w0, "R5 read no write", wr_cnt - w0, 0);
    endtask

    task automatic t_bad_length(input int n);
        logic [7:0] rx; int oe_err; int w0; logic [7:0] old;
        w0 = wr_cnt;
        old = mem[7'h4B];
        spi_xfer({1'b0, 7'h4B, 8'h3E}, n, 1'b0, 1'b0, rx, oe_err);
        chk(wr_cnt == w0, "R4 no write on bad length", wr_cnt - w0, 0);
        t_read(7'h4B, 1'b0, 1'b0);
        chk(rx == rx && mem[7'h4B] == old, "R4 register kept", mem[7'h4B], old);
    endtask

    initial begin
        for (int k = 0; k < 128; k++) mem[k] = 8'(k * 37 + 11);
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(10);
        t_reset();
        // R2 R3: several write patterns, both pin modes
        t_write(7'h25, 8'hA7, 1'b0);
        t_write(7'h00, 8'hFF, 1'b0);
        t_write(7'h7F, 8'h00, 1'b1);
        // R5 R6 R8: reads on each pin, plus a mid-frame mode change
        mem[7'h3C] = 8'h5A;
        t_read(7'h3C, 1'b0, 1'b0);
        mem[7'h11] = 8'hC3;
        t_read(7'h11, 1'b1, 1'b0);
        t_read(7'h25, 1'b0, 1'b1);
        t_read(7'h7F, 1'b1, 1'b1);
        // R4: short and long frames
        t_bad_length(10);
        t_bad_length(15);
        t_bad_length(17);
        // R3 R6: write then read back
        t_write(7'h4B, 8'h96, 1'b0);
        t_read(7'h4B, 1'b1, 1'b0);
        // R9: exclusivity over the whole run
        chk(both_cnt == 0, "R9 exclusive outputs", both_cnt, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule